// File: doc/BRIEF.md
# PCM Time-Slot Window Generator

This block produces the receive and transmit enable windows that a serial line controller needs when it shares a time-division multiplexed PCM highway. A single bit clock, supplied from outside and common to both directions, drives every register. A frame synchronization input restarts a cycle counter at every frame boundary. Each direction compares that counter against its own programmed position and width and raises its enable for exactly the bit periods of its time slot.

Each direction selects a slot of eight bits out of 64. It then adds a fine shift of 0 to 7 bits, and the shift's lowest bit arrives on a separate input from its upper bits. The window opens between 1 and 512 clocks after the frame sync and stays open for 1 to 256 clocks. Configuration is sampled only on the frame sync edge, so software may rewrite it at any time without disturbing the window of the current frame.

Top module: `pcm_slot_window`

## Requirements
- R1: After reset, and until the first clock edge that samples fsync_i high, rx_en_o and tx_en_o stay 0.
- R2: The position is pos = slot*8 + shift, where shift = {shift_hi_i[1:0], shift_lo_i}, with shift_lo_i as bit 0. If fsync_i is sampled high at edge k, the enable first reads 1 after edge k+pos+1.
- R3: The width input holds N-1. After opening, the enable stays 1 for exactly width+1 consecutive cycles, that is, through edge k+pos+width+1, and reads 0 after the next edge.
- R4: The receive and transmit windows are computed independently. Each uses only its own slot, shift and width inputs.
- R5: An edge that samples fsync_i high restarts the frame. Both enables read 0 after that edge, even when a window was open.
- R6: Slot, shift and width are captured only at the edge that samples fsync_i high. Changes made later in the frame have no effect until the next frame sync.
- R7: The extreme settings work: position 511 with width 255 opens 512 clocks after frame sync and closes after clock 767.
- R8: Once a window has closed, its enable stays 0 for the rest of the frame, however long the frame runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared receive/transmit bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame synchronization, sampled on rising edge |
| rx_slot_i | input | 6 | Receive slot index |
| rx_shift_hi_i | input | 2 | Receive shift bits 2:1 |
| rx_shift_lo_i | input | 1 | Receive shift bit 0 |
| rx_width_i | input | 8 | Receive window width minus one |
| tx_slot_i | input | 6 | Transmit slot index |
| tx_shift_hi_i | input | 2 | Transmit shift bits 2:1 |
| tx_shift_lo_i | input | 1 | Transmit shift bit 0 |
| tx_width_i | input | 8 | Transmit window width minus one |
| rx_en_o | output | 1 | Receive window enable |
| tx_en_o | output | 1 | Transmit window enable |

## Verification
Each frame is compared cycle by cycle against a window computed from the configured position and width. The smallest setting (slot 0, no shift, width 1) exposes off-by-one errors in the opening delay. A pair of directions that differ only in the low shift bit shows whether that separate input lands in bit 0. The largest position combined with the largest width exercises the counter range, and receive and transmit settings that differ from each other show whether the directions are kept apart. The remaining frames are cut short by an early frame sync, or have their configuration rewritten partway through. These separate a correct restart and a sync-only capture from designs that follow live inputs.

// File: rtl/pcm_win_pkg.sv
package pcm_win_pkg;
  localparam int unsigned NUM_DIR = 2;
  typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} win_dir_e;
endpackage

// File: rtl/pcm_frame_counter.sv
module pcm_frame_counter #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      run_o <= 1'b0;
    end else if (fsync_i) begin
      cnt_o <= '0;
      run_o <= 1'b1;
    end else if (run_o && cnt_o != CNT_MAX) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/pcm_cfg_hold.sv
module pcm_cfg_hold #(
  parameter int unsigned POS_W = 9,
  parameter int unsigned WID_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [WID_W-1:0] width_i,
  output logic [POS_W-1:0] pos_o,
  output logic [WID_W-1:0] width_o
);
  // shadow copy, updated only on frame boundaries
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o   <= '0;
      width_o <= '0;
    end else if (fsync_i) begin
      pos_o   <= pos_i;
      width_o <= width_i;
    end
  end
endmodule

// File: rtl/pcm_win_gen.sv
module pcm_win_gen #(
  parameter int unsigned POS_W = 9,
  parameter int unsigned WID_W = 8,
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [WID_W-1:0] width_i,
  output logic             en_o
);
  logic [CNT_W-1:0] start_c;
  logic [CNT_W-1:0] stop_c;
  logic             en_d;

  assign start_c = CNT_W'(pos_i);
  // first count past the window: pos + width + 1
  assign stop_c  = CNT_W'(pos_i) + CNT_W'(width_i) + CNT_W'(1);

  always_comb begin
    en_d = run_i && !fsync_i && (cnt_i >= start_c) && (cnt_i < stop_c);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= 1'b0;
    else         en_o <= en_d;
  end
endmodule

// File: rtl/pcm_slot_window.sv
module pcm_slot_window #(
  parameter int unsigned SLOT_W  = 6,
  parameter int unsigned SHIFT_W = 3,
  parameter int unsigned WID_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fsync_i,
  input  logic [SLOT_W-1:0]  rx_slot_i,
  input  logic [SHIFT_W-2:0] rx_shift_hi_i,
  input  logic               rx_shift_lo_i,
  input  logic [WID_W-1:0]   rx_width_i,
  input  logic [SLOT_W-1:0]  tx_slot_i,
  input  logic [SHIFT_W-2:0] tx_shift_hi_i,
  input  logic               tx_shift_lo_i,
  input  logic [WID_W-1:0]   tx_width_i,
  output logic               rx_en_o,
  output logic               tx_en_o
);
  import pcm_win_pkg::*;

  localparam int unsigned POS_W = SLOT_W + SHIFT_W;
  localparam int unsigned CNT_W = ((POS_W > WID_W) ? POS_W : WID_W) + 2;

  logic [CNT_W-1:0] cnt;
  logic             run;
  logic [POS_W-1:0] pos_in   [NUM_DIR];
  logic [WID_W-1:0] wid_in   [NUM_DIR];
  logic [POS_W-1:0] pos_held [NUM_DIR];
  logic [WID_W-1:0] wid_held [NUM_DIR];
  logic [NUM_DIR-1:0] en;

  assign pos_in[DIR_RX] = {rx_slot_i, rx_shift_hi_i, rx_shift_lo_i};
  assign pos_in[DIR_TX] = {tx_slot_i, tx_shift_hi_i, tx_shift_lo_i};
  assign wid_in[DIR_RX] = rx_width_i;
  assign wid_in[DIR_TX] = tx_width_i;

  pcm_frame_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fsync_i (fsync_i),
    .cnt_o   (cnt),
    .run_o   (run)
  );

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    pcm_cfg_hold #(.POS_W(POS_W), .WID_W(WID_W)) u_hold (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fsync_i (fsync_i),
      .pos_i   (pos_in[d]),
      .width_i (wid_in[d]),
      .pos_o   (pos_held[d]),
      .width_o (wid_held[d])
    );

    pcm_win_gen #(.POS_W(POS_W), .WID_W(WID_W), .CNT_W(CNT_W)) u_win (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fsync_i (fsync_i),
      .run_i   (run),
      .cnt_i   (cnt),
      .pos_i   (pos_held[d]),
      .width_i (wid_held[d]),
      .en_o    (en[d])
    );
  end

  assign rx_en_o = en[DIR_RX];
  assign tx_en_o = en[DIR_TX];
endmodule

// File: rtl/pcm_slot_window_chk.sv
module pcm_slot_window_chk #(
  parameter int unsigned SLOT_W  = 6,
  parameter int unsigned SHIFT_W = 3,
  parameter int unsigned WID_W   = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic fsync_i,
  input logic rx_en_o,
  input logic tx_en_o
);
  localparam int unsigned POS_W = SLOT_W + SHIFT_W;
  localparam int unsigned SIN_W = POS_W + 2;
  localparam int unsigned RUN_W = WID_W + 2;
  localparam logic [SIN_W-1:0] MAX_OPEN = SIN_W'(2 ** POS_W);
  localparam logic [RUN_W-1:0] MAX_RUN  = RUN_W'(2 ** WID_W - 1);

  logic             seen;
  logic [SIN_W-1:0] since;
  logic [RUN_W-1:0] rx_run, tx_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen   <= 1'b0;
      since  <= '0;
      rx_run <= '0;
      tx_run <= '0;
    end else begin
      if (fsync_i) begin
        seen  <= 1'b1;
        since <= '0;
      end else if (since != '1) begin
        since <= since + 1'b1;
      end
      rx_run <= rx_en_o ? ((rx_run != '1) ? rx_run + 1'b1 : rx_run) : '0;
      tx_run <= tx_en_o ? ((tx_run != '1) ? tx_run + 1'b1 : tx_run) : '0;
    end
  end

  assert_idle_before_sync_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen |-> (!rx_en_o && !tx_en_o));

  assert_sync_closes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_i |=> (!rx_en_o && !tx_en_o));

  assert_rx_open_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_en_o) |-> (seen && since >= 1 && since <= MAX_OPEN));

  assert_tx_open_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> (seen && since >= 1 && since <= MAX_OPEN));

  assert_rx_width_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_en_o |-> rx_run <= MAX_RUN);

  assert_tx_width_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o |-> tx_run <= MAX_RUN);
endmodule

bind pcm_slot_window pcm_slot_window_chk #(
  .SLOT_W(SLOT_W), .SHIFT_W(SHIFT_W), .WID_W(WID_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .fsync_i (fsync_i),
  .rx_en_o (rx_en_o),
  .tx_en_o (tx_en_o)
);

// File: tb/tb_pcm_slot_window.sv
`timescale 1ns/1ps
module tb_pcm_slot_window;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fsync_i = 1'b0;
  logic [5:0] rx_slot_i = '0, tx_slot_i = '0;
  logic [1:0] rx_shift_hi_i = '0, tx_shift_hi_i = '0;
  logic       rx_shift_lo_i = 1'b0, tx_shift_lo_i = 1'b0;
  logic [7:0] rx_width_i = '0, tx_width_i = '0;
  logic       rx_en_o, tx_en_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pcm_slot_window dut (
    .clk_i, .rst_ni, .fsync_i,
    .rx_slot_i, .rx_shift_hi_i, .rx_shift_lo_i, .rx_width_i,
    .tx_slot_i, .tx_shift_hi_i, .tx_shift_lo_i, .tx_width_i,
    .rx_en_o, .tx_en_o
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int rs, input int rsh, input int rw,
                         input int ts, input int tsh, input int tw);
    rx_slot_i = 6'(rs); rx_shift_hi_i = 2'(rsh >> 1); rx_shift_lo_i = rsh[0];
    rx_width_i = 8'(rw);
    tx_slot_i = 6'(ts); tx_shift_hi_i = 2'(tsh >> 1); tx_shift_lo_i = tsh[0];
    tx_width_i = 8'(tw);
  endtask

  // one frame: sync pulse, then len cycles checked against the expected window
  task automatic run_frame(input string req, input int rs, input int rsh, input int rw,
                           input int ts, input int tsh, input int tw,
                           input int len, input int chg_at);
    int rpos = rs * 8 + rsh;
    int tpos = ts * 8 + tsh;
    int rbad = 0, tbad = 0, ract = 0, rexp = 0, tact = 0, texp = 0;
    @(negedge clk_i);
    set_cfg(rs, rsh, rw, ts, tsh, tw);
    fsync_i = 1'b1;
    @(negedge clk_i);
    fsync_i = 1'b0;
    check("R5", {30'd0, rx_en_o, tx_en_o}, 0, "enables right after frame sync");
    for (int j = 1; j <= len; j++) begin
      if (j == chg_at) set_cfg(0, 0, 255, 0, 0, 255); // R6: late rewrite
      @(negedge clk_i);
      begin
        int re = (j >= rpos + 1 && j <= rpos + rw + 1) ? 1 : 0;
        int te = (j >= tpos + 1 && j <= tpos + tw + 1) ? 1 : 0;
        if (int'(rx_en_o) != re && rbad == 0) begin ract = int'(rx_en_o); rexp = re; rbad = j; end
        if (int'(tx_en_o) != te && tbad == 0) begin tact = int'(tx_en_o); texp = te; tbad = j; end
      end
    end
    check(req, ract, rexp, $sformatf("rx window (first bad cycle %0d)", rbad));
    check(req, tact, texp, $sformatf("tx window (first bad cycle %0d)", tbad));
  endtask

  task automatic t_reset_idle;
    int bad = 0;
    for (int j = 0; j < 50; j++) begin
      @(negedge clk_i);
      if (rx_en_o || tx_en_o) bad++;
    end
    check("R1", bad, 0, "enabled cycles before first frame sync");
  endtask

  task automatic t_min_and_independent;
    run_frame("R2 R3 R4", 0, 0, 0, 1, 3, 7, 40, 0);
  endtask

  task automatic t_shift_lsb;
    run_frame("R2", 2, 5, 3, 2, 4, 3, 40, 0);
  endtask

  task automatic t_extreme;
    run_frame("R7 R3", 63, 7, 255, 0, 0, 255, 800, 0);
  endtask

  task automatic t_cut_short;
    run_frame("R5", 1, 0, 100, 0, 2, 200, 30, 0);
    run_frame("R5 R4", 0, 1, 2, 3, 0, 1, 40, 0);
  endtask

  task automatic t_late_change;
    run_frame("R6", 3, 0, 4, 1, 6, 2, 60, 3);
    run_frame("R6", 0, 0, 255, 0, 0, 255, 270, 0);
  endtask

  task automatic t_long_tail;
    run_frame("R8", 0, 2, 1, 4, 0, 0, 600, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset_idle();
    t_min_and_independent();
    t_shift_lsb();
    t_extreme();
    t_cut_short();
    t_late_change();
    t_long_tail();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule